// File: doc/BRIEF.md
# Keyboard-Controller Address-Line-20 Gate

This block models the old path through a slow keyboard controller that decides whether physical address line 20 reaches memory. The host sees two byte-wide ports. One is the command port and the other is the data port. Each port can be written, and each has a read view.

Software enables or disables the line in two steps:

- It writes the output-port write command (0xD1) to the command port.
- It then writes the new output-port value to the data port.

Bit 1 of that output-port value drives the gate.

After every accepted write, the controller is busy for a programmable number of cycles. Software has to poll the status byte until the busy bit clears before it writes again. A write that arrives while the controller is busy is dropped and counted.

The block also forms the 21-bit real-mode address `segment * 16 + offset` and passes it through the gate. When the line is disabled, any address at or above 1 MB wraps back into low memory.

Top module: `kbc_a20_gate`

## Requirements
- R1: After synchronous reset, the output-port register is 0x00, `a20_en` is 0, the status byte reads 0x00, and `err_count` is 0.
- R2: An accepted command-port write of 0xD1 arms an output-port write. The next accepted data-port write loads its byte into the output-port register. A data byte of 0xDF turns `a20_en` on and a data byte of 0xDD turns it off.
- R3: `a20_en` always equals bit 1 of the output-port register, for any loaded value.
- R4: A data-port write while not armed is discarded and leaves the output port unchanged. A command-port write of any value other than 0xD1 disarms a pending write.
- R5: After an accepted write on either port, status bit 1 (value 0x02) reads 1 for exactly `BUSY_CYC` cycles. All other status bits read 0.
- R6: A write on either port that arrives while busy is ignored. It changes neither the output port nor the arm state, and it does not restart the busy window. Each such write increments `err_count`, which saturates at its maximum value.
- R7: `phys_addr` is `{a20_en & raw[20], raw[19:0]}`, where `raw = seg_in*16 + off_in` is 21 bits wide. For FFFF:FFFF this gives 0x10FFEF when the line is enabled and 0x0FFEF when it is disabled.
- R8: Reading with `host_rd_port`=0 (data port) returns the output-port register. Reading with `host_rd_port`=1 (command port) returns the status byte.
- R9: One 0xD1 command arms exactly one data write. A second data write after it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_port | input | 1 | Write target: 0 = data port, 1 = command port |
| host_wdata | input | 8 | Write byte |
| host_rd_port | input | 1 | Read select: 0 = output-port register, 1 = status byte |
| host_rdata | output | 8 | Read byte (combinational) |
| seg_in | input | 16 | Real-mode segment |
| off_in | input | 16 | Real-mode offset |
| phys_addr | output | 21 | Gated physical address |
| a20_en | output | 1 | Address line 20 enable |
| err_count | output | ERR_W | Count of writes dropped while busy (saturating) |

## Verification
The bench targets the edges of the busy window. It issues one write on the last busy cycle and another on the first idle cycle. A timer that is off by one would drop the second write or accept the first. A timer that restarts on a rejected write would still be busy on the cycle after the window should have closed.

It also sends data bytes that are not armed, data bytes after a foreign command, and a second data byte after one arm. A decoder that never disarms would corrupt the gate in any of these cases.

Address checks at FFFF:FFFF and at random segment/offset pairs, with the gate in both states, expose a wrap that is missing or one that is applied to the wrong bit.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    typedef enum logic {
        PORT_DATA = 1'b0,
        PORT_CMD  = 1'b1
    } kbc_port_e;

    typedef struct packed {
        logic      valid;
        kbc_port_e port;
        logic [7:0] data;
    } kbc_wr_t;

    localparam logic [7:0] CMD_WRITE_OUTPORT = 8'hD1;
    localparam int         OUT_GATE_BIT      = 1;
    localparam int         STAT_BUSY_BIT     = 1;
    localparam int         ADDR_W            = 21;

    function automatic logic [ADDR_W-1:0] real_mode_addr(input logic [15:0] seg,
                                                         input logic [15:0] off);
        return {1'b0, seg, 4'b0000} + {5'b00000, off};
    endfunction

    function automatic logic [7:0] status_byte(input logic busy);
        logic [7:0] s;
        s = 8'h00;
        s[STAT_BUSY_BIT] = busy;
        return s;
    endfunction

endpackage

// File: rtl/kbc_busy_timer.sv
module kbc_busy_timer #(
    parameter int BUSY_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic wr_seen,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(BUSY_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign busy = (cnt != '0);

    // R5: an accepted write opens a window of exactly BUSY_CYC cycles.
    p_busy_load_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == CNT_W'(BUSY_CYC)));

    // R6: a write that arrives while busy does not restart the window.
    p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_seen && busy) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  kbc_wr_t          req,
    input  logic             busy,
    output logic             accept,
    output logic [7:0]       outport,
    output logic [ERR_W-1:0] err_count
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic armed;
    logic load_out;

    assign accept   = req.valid && !busy;
    assign load_out = accept && (req.port == PORT_DATA) && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (accept) begin
            if (req.port == PORT_CMD) begin
                armed <= (req.data == CMD_WRITE_OUTPORT);
            end else begin
                armed <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            outport <= 8'h00;
        end else if (load_out) begin
            outport <= req.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_count <= '0;
        end else if (req.valid && busy && (err_count != ERR_MAX)) begin
            err_count <= err_count + ERR_W'(1);
        end
    end

    // R4: without an armed data write, the output port keeps its value.
    p_outport_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(req.valid && req.port == PORT_DATA && armed && !busy) |=> $stable(outport));

    // R9: a data write consumes the arm.
    p_arm_consumed_r9: assert property (@(posedge clk) disable iff (rst)
        (accept && req.port == PORT_DATA) |=> !armed);

    // R6: each write rejected while busy bumps the error count until it saturates.
    p_err_inc_r6: assert property (@(posedge clk) disable iff (rst)
        (req.valid && busy && err_count != ERR_MAX) |=> (err_count == $past(err_count) + ERR_W'(1)));

    // R6: a rejected write leaves the arm state alone.
    p_arm_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (req.valid && busy) |=> $stable(armed));

endmodule

// File: rtl/kbc_addr_gate.sv
module kbc_addr_gate
    import kbc_pkg::*;
(
    input  logic [15:0]       seg_in,
    input  logic [15:0]       off_in,
    input  logic              gate_en,
    output logic [ADDR_W-1:0] phys_addr
);
    logic [ADDR_W-1:0] raw;

    always_comb begin
        raw       = real_mode_addr(seg_in, off_in);
        phys_addr = {gate_en & raw[ADDR_W-1], raw[ADDR_W-2:0]};
    end

    // R7: with the gate closed, address line 20 is never driven.
    always_comb begin
        a_wrap_r7: assert (gate_en || !phys_addr[ADDR_W-1]);
    end

endmodule

// File: rtl/kbc_a20_gate.sv
module kbc_a20_gate
    import kbc_pkg::*;
#(
    parameter int BUSY_CYC = 16,
    parameter int ERR_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_port,
    input  logic [7:0]       host_wdata,
    input  logic             host_rd_port,
    output logic [7:0]       host_rdata,
    input  logic [15:0]      seg_in,
    input  logic [15:0]      off_in,
    output logic [20:0]      phys_addr,
    output logic             a20_en,
    output logic [ERR_W-1:0] err_count
);
    kbc_wr_t    req;
    logic       busy;
    logic       accept;
    logic [7:0] outport;

    assign req.valid = host_wr;
    assign req.port  = kbc_port_e'(host_port);
    assign req.data  = host_wdata;

    kbc_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .wr_seen (host_wr),
        .busy    (busy)
    );

    kbc_cmd_decode #(.ERR_W(ERR_W)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .busy      (busy),
        .accept    (accept),
        .outport   (outport),
        .err_count (err_count)
    );

    assign a20_en     = outport[OUT_GATE_BIT];
    assign host_rdata = host_rd_port ? status_byte(busy) : outport;

    kbc_addr_gate u_gate (
        .seg_in    (seg_in),
        .off_in    (off_in),
        .gate_en   (a20_en),
        .phys_addr (phys_addr)
    );

    // R6: nothing is accepted while the busy window is open.
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (host_wr && busy) |=> $stable(outport));

endmodule

// File: tb/kbc_a20_gate_tb.sv
module kbc_a20_gate_tb;
    localparam int BUSY  = 16;
    localparam int ERR_W = 8;

    logic clk = 0;
    logic rst = 1;
    logic host_wr = 0;
    logic host_port = 0;
    logic [7:0] host_wdata = 0;
    logic host_rd_port = 0;
    logic [7:0] host_rdata;
    logic [15:0] seg_in = 0;
    logic [15:0] off_in = 0;
    logic [20:0] phys_addr;
    logic a20_en;
    logic [ERR_W-1:0] err_count;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] exp_out = 8'h00;
    int exp_err = 0;

    always #5 clk = ~clk;

    kbc_a20_gate #(.BUSY_CYC(BUSY), .ERR_W(ERR_W)) u_dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_port(host_port),
        .host_wdata(host_wdata), .host_rd_port(host_rd_port), .host_rdata(host_rdata),
        .seg_in(seg_in), .off_in(off_in), .phys_addr(phys_addr),
        .a20_en(a20_en), .err_count(err_count)
    );

    function automatic logic [20:0] model_addr(input logic [15:0] s, input logic [15:0] o,
                                               input logic en);
        int unsigned r;
        r = int'(s) * 16 + int'(o);
        return {en & r[20], r[19:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic port, input logic [7:0] d);
        host_wr = 1; host_port = port; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic read_port(input logic port, output logic [7:0] v);
        host_rd_port = port;
        #1;
        v = host_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        read_port(1'b1, s);
        while (s[1]) begin
            @(negedge clk);
            read_port(1'b1, s);
        end
    endtask

    task automatic check_state(input string req);
        logic [7:0] v;
        read_port(1'b0, v);
        chk({req, " outport"}, 32'(v), 32'(exp_out));
        chk({req, " a20_en"}, 32'(a20_en), 32'(exp_out[1]));
    endtask

    task automatic check_addr(input string req, input logic [15:0] s, input logic [15:0] o);
        seg_in = s; off_in = o;
        #1;
        chk(req, 32'(phys_addr), 32'(model_addr(s, o, exp_out[1])));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        int unsigned seed;
        seed = $urandom(32'h5EED1234);

        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        read_port(1'b1, v); chk("R1 status", 32'(v), 32'h00);
        read_port(1'b0, v); chk("R1 outport", 32'(v), 32'h00);
        chk("R1 a20_en", 32'(a20_en), 0);
        chk("R1 err_count", 32'(err_count), 0);
        check_addr("R1 wrap FFFF:FFFF", 16'hFFFF, 16'hFFFF);
        chk("R7 wrapped value", 32'(phys_addr), 32'h0FFEF);

        // R5: busy window length and status encoding
        do_write(1'b1, 8'hD1);
        read_port(1'b1, v); chk("R5 status while busy", 32'(v), 32'h02);
        n = 0;
        while (v[1] && n < 1000) begin
            n++;
            @(negedge clk);
            read_port(1'b1, v);
        end
        chk("R5 busy length", 32'(n), 32'(BUSY));

        // R2: enable with 0xDF
        do_write(1'b0, 8'hDF); exp_out = 8'hDF;
        wait_idle();
        check_state("R2 enable"); // also R8 data-port read
        check_addr("R7 FFFF:FFFF enabled", 16'hFFFF, 16'hFFFF);
        chk("R7 enabled value", 32'(phys_addr), 32'h10FFEF);

        // R6: write on the last busy cycle is dropped, window not restarted
        do_write(1'b1, 8'hD1);
        repeat (BUSY - 1) @(negedge clk);
        do_write(1'b0, 8'h00); exp_err++;
        read_port(1'b1, v); chk("R6 no restart of busy", 32'(v), 32'h00);
        check_state("R6 ignored data");
        chk("R6 err_count", 32'(err_count), 32'(exp_err));
        // first idle cycle: accepted (arm was kept), R2 disable with 0xDD
        do_write(1'b0, 8'hDD); exp_out = 8'hDD;
        wait_idle();
        check_state("R2 disable");
        check_addr("R7 FFFF:FFFF disabled", 16'hFFFF, 16'hFFFF);

        // R6: back-to-back write dropped, arm survives
        do_write(1'b1, 8'hD1);
        do_write(1'b0, 8'h02); exp_err++;
        wait_idle();
        check_state("R6 back-to-back");
        do_write(1'b0, 8'h02); exp_out = 8'h02;
        wait_idle();
        check_state("R3 bit1 only");

        // R9: arm consumed
        do_write(1'b0, 8'h00);
        wait_idle();
        check_state("R9 second data discarded");

        // R4: unarmed data and foreign command
        do_write(1'b1, 8'hAA); wait_idle();
        do_write(1'b0, 8'h00); wait_idle();
        check_state("R4 unarmed data");
        do_write(1'b1, 8'hD1); wait_idle();
        do_write(1'b1, 8'h55); wait_idle();
        do_write(1'b0, 8'h00); wait_idle();
        check_state("R4 disarmed by other command");

        // random mix
        for (int i = 0; i < 60; i++) begin
            int op;
            logic [7:0] d;
            op = $urandom % 4;
            d = 8'($urandom);
            case (op)
                0: begin
                    do_write(1'b1, 8'hD1); wait_idle();
                    do_write(1'b0, d); wait_idle();
                    exp_out = d;
                    check_state("R3 random armed write");
                end
                1: begin
                    do_write(1'b0, d); wait_idle();
                    check_state("R4 random unarmed write");
                end
                2: begin
                    do_write(1'b1, (d == 8'hD1) ? 8'h20 : d); wait_idle();
                    do_write(1'b0, ~d); wait_idle();
                    check_state("R4 random foreign command");
                end
                default: begin
                    check_addr("R7 random address", 16'($urandom), 16'($urandom));
                end
            endcase
        end

        chk("R6 final err_count", 32'(err_count), 32'(exp_err));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule